// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command bus of a four-bank single-data-rate SDRAM from the moment reset is released until the device can take normal traffic. It first holds the bus quiet for a power-up wait. The length of that wait is derived from the clock frequency and a wait time in microseconds. During the wait it drives command-inhibit while in reset and NOP afterwards.

Once the wait has elapsed, the block issues one precharge aimed at every bank. It then issues a parameterised number of auto-refresh commands, never fewer than two. Finally it writes the mode register from the burst-length, burst-type and CAS-latency configuration inputs. Parameterised gap timers enforce the precharge-to-refresh, refresh-to-refresh, refresh-to-load and load-to-use spacings, and only NOPs appear during each gap.

When the last gap has expired, a ready flag goes high and stays high until the next reset. Clock enable and the data masks are held high for the whole sequence.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low, the bus shows command-inhibit: cs_n, ras_n, cas_n and we_n are all 1, the address and bank are 0 and ready is 0. CKE and every DQM bit are 1 in reset and on every cycle of the sequence.
- R2: Count rising edges after reset release as cycles 1, 2, .... Cycles 1 to WAIT_CYC-1 carry NOP, encoded as {cs_n,ras_n,cas_n,we_n}=0111, where WAIT_CYC = CLK_MHZ*WAIT_US. No other command appears in that window, and the cycle just before the precharge is always a NOP.
- R3: Cycle WAIT_CYC carries precharge (0010) with address bit 10 set, all other address bits 0 and the bank 0.
- R4: The first auto-refresh (0001) appears exactly T_RP cycles after the precharge, with NOPs in between.
- R5: Exactly NUM_REF auto-refreshes are issued, each T_RC cycles after the one before, with NOPs in between. A refresh never precedes the precharge.
- R6: The mode-register load (0000) appears T_RC cycles after the last refresh. Its bank is 0 and its address carries burst length in bits 2:0, burst type in bit 3 and CAS latency in bits 6:4, with every other bit 0. It never appears before all refreshes have been issued.
- R7: ready_o rises exactly T_MRD cycles after the load, and only NOPs appear from the load until then and afterwards. Once high, ready_o stays high until reset.
- R8: The mode fields are taken from the configuration inputs present at the clock edge that issues the load. Earlier values have no effect.
- R9: Asserting reset at any point of the sequence returns the bus to command-inhibit at once. After release the whole sequence restarts from the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all outputs change on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| burst_len_i | input | 3 | Burst-length code for mode bits 2:0 |
| burst_type_i | input | 1 | Burst type for mode bit 3 |
| cas_lat_i | input | 3 | CAS latency for mode bits 6:4 |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable, held high |
| dqm_o | output | DQM_W | Data masks, held high |
| ba_o | output | BANK_W | Bank address |
| addr_o | output | ROW_W | Address bus |
| ready_o | output | 1 | Initialization complete |

## Verification
Two events coincide when the refresh-to-refresh gap expires: the refresh counter reaching NUM_REF and the gap timer reaching zero fall on the same edge, and that edge must choose between another refresh and the mode load. The bench instantiates the block with three refreshes and compares the bus on every cycle against a schedule computed from the parameters, so an off-by-one in either counter shows up as a command at the wrong cycle. A second collision is provoked by asserting reset just after the first refresh, when both the gap timer and the refresh counter hold mid-sequence state. The bench judges it by an immediate return to inhibit and a full, correctly timed restart.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111,
    CMD_INH = 4'b1111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_PRE,
    ST_TRP,
    ST_REF,
    ST_TRC,
    ST_MRS,
    ST_TMRD,
    ST_DONE
  } init_state_e;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= RST_VAL;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_mode.sv
module sdram_init_mode #(
  parameter int unsigned ROW_W = 12
) (
  input  logic [2:0]       burst_len_i,
  input  logic             burst_type_i,
  input  logic [2:0]       cas_lat_i,
  output logic [ROW_W-1:0] mode_o
);

  // bits 8:7 standard op, bit 9 programmed write burst, upper bits reserved
  always_comb begin
    mode_o      = '0;
    mode_o[2:0] = burst_len_i;
    mode_o[3]   = burst_type_i;
    mode_o[6:4] = cas_lat_i;
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 200,
  parameter int unsigned WAIT_US = 100,
  parameter int unsigned T_RP    = 3,
  parameter int unsigned T_RC    = 10,
  parameter int unsigned T_MRD   = 2,
  parameter int unsigned NUM_REF = 2,
  parameter int unsigned ROW_W   = 12,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned DQM_W   = 4,
  parameter int unsigned AP_BIT  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  input  logic [2:0]        cas_lat_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              cke_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic              ready_o
);

  // all gaps assumed >= 2 cycles, WAIT_CYC >= 2, NUM_REF >= 2
  localparam int unsigned WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int unsigned GAP_MAX  = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                                   : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int unsigned MAX_CNT  = (WAIT_CYC > GAP_MAX) ? WAIT_CYC : GAP_MAX;
  localparam int unsigned CNT_W    = $clog2(MAX_CNT + 1);
  localparam int unsigned REF_W    = $clog2(NUM_REF + 1);
  localparam logic [ROW_W-1:0] PRE_ALL = ROW_W'(1) << AP_BIT;

  init_state_e       state_q, state_d;
  logic [REF_W-1:0]  ref_q, ref_d;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic [ROW_W-1:0]  mode_word;
  sdram_cmd_e        cmd_q;
  logic [ROW_W-1:0]  addr_q;
  logic              ready_q;

  sdram_init_timer #(
    .W       (CNT_W),
    .RST_VAL (CNT_W'(WAIT_CYC - 1))
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sdram_init_mode #(.ROW_W(ROW_W)) u_mode (
    .burst_len_i  (burst_len_i),
    .burst_type_i (burst_type_i),
    .cas_lat_i    (cas_lat_i),
    .mode_o       (mode_word)
  );

  always_comb begin
    state_d  = state_q;
    ref_d    = ref_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_WAIT: if (tmr_zero) state_d = ST_PRE;
      ST_PRE: begin
        state_d  = ST_TRP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RP - 2);
      end
      ST_TRP: if (tmr_zero) state_d = ST_REF;
      ST_REF: begin
        ref_d    = ref_q + 1'b1;
        state_d  = ST_TRC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RC - 2);
      end
      ST_TRC: if (tmr_zero) state_d = (ref_q == REF_W'(NUM_REF)) ? ST_MRS : ST_REF;
      ST_MRS: begin
        state_d  = ST_TMRD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_MRD - 2);
      end
      ST_TMRD: if (tmr_zero) state_d = ST_DONE;
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      ref_q   <= '0;
      cmd_q   <= CMD_INH;
      addr_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
      ready_q <= (state_d == ST_DONE);
      unique case (state_d)
        ST_PRE:  begin cmd_q <= CMD_PRE; addr_q <= PRE_ALL;   end
        ST_REF:  begin cmd_q <= CMD_REF; addr_q <= '0;        end
        ST_MRS:  begin cmd_q <= CMD_LMR; addr_q <= mode_word; end
        default: begin cmd_q <= CMD_NOP; addr_q <= '0;        end
      endcase
    end
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign addr_o  = addr_q;
  assign ba_o    = '0;
  assign cke_o   = 1'b1;
  assign dqm_o   = '1;
  assign ready_o = ready_q;

  // ---------------- assertions ----------------
  logic             pre_seen_q, lmr_seen_q;
  logic [REF_W:0]   ref_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_seen_q <= 1'b0;
      lmr_seen_q <= 1'b0;
      ref_seen_q <= '0;
    end else begin
      if (cmd_q == CMD_PRE) pre_seen_q <= 1'b1;
      if (cmd_q == CMD_LMR) lmr_seen_q <= 1'b1;
      if (cmd_q == CMD_REF && ref_seen_q != '1) ref_seen_q <= ref_seen_q + 1'b1;
    end
  end

  p_nop_before_pre_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_PRE) |-> ($past(cmd_q) == CMD_NOP));

  p_pre_all_banks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_PRE) |-> (addr_o[AP_BIT] && ba_o == '0));

  p_ref_after_pre_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_REF) |-> pre_seen_q);

  p_lmr_after_refs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_LMR) |-> (ref_seen_q >= (REF_W+1)'(NUM_REF)));

  p_ready_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  p_ready_after_lmr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> lmr_seen_q);

endmodule

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

  localparam int unsigned CLK_MHZ = 200;
  localparam int unsigned WAIT_US = 100;
  localparam int unsigned T_RP    = 3;
  localparam int unsigned T_RC    = 8;
  localparam int unsigned T_MRD   = 2;
  localparam int unsigned NUM_REF = 3;
  localparam int unsigned WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int unsigned K_PRE  = WAIT_CYC;
  localparam int unsigned K_REF0 = K_PRE + T_RP;
  localparam int unsigned K_LMR  = K_REF0 + NUM_REF * T_RC;
  localparam int unsigned K_RDY  = K_LMR + T_MRD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bl = 3'd0, cl = 3'd0;
  logic bt = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, cke, rdy;
  logic [3:0]  dqm;
  logic [1:0]  ba;
  logic [11:0] addr;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .T_RP(T_RP),
    .T_RC(T_RC), .T_MRD(T_MRD), .NUM_REF(NUM_REF)
  ) u_sdram_init_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .burst_len_i(bl), .burst_type_i(bt), .cas_lat_i(cl),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .cke_o(cke), .dqm_o(dqm), .ba_o(ba), .addr_o(addr), .ready_o(rdy)
  );

  // packed view: cmd4 addr12 ba2 rdy1 cke1 dqm4
  function automatic logic [23:0] bus();
    return {cs_n, ras_n, cas_n, we_n, addr, ba, rdy, cke, dqm};
  endfunction

  function automatic logic [23:0] pack(logic [3:0] c, logic [11:0] a, logic r);
    return {c, a, 2'b00, r, 1'b1, 4'hf};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reset_check();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(bus() === pack(4'b1111, 12'h0, 1'b0), "R1 reset inhibit", bus(), pack(4'b1111, 12'h0, 1'b0));
    repeat (3) @(negedge clk);
    chk(bus() === pack(4'b1111, 12'h0, 1'b0), "R1 held in reset", bus(), pack(4'b1111, 12'h0, 1'b0));
  endtask

  // runs a full sequence; late_cfg drives decoy config until the load edge (R8)
  task automatic run_sequence(input logic [2:0] b_len, input logic b_type, input logic [2:0] c_lat,
                              input bit late_cfg);
    logic [23:0] e;
    string tag;
    bl = late_cfg ? ~b_len : b_len;
    bt = late_cfg ? ~b_type : b_type;
    cl = late_cfg ? ~c_lat : c_lat;
    reset_check();
    rst_n = 1'b1;
    for (int k = 1; k <= int'(K_RDY) + 6; k++) begin
      @(negedge clk);
      if (late_cfg && k == int'(K_LMR) - 1) begin
        bl = b_len; bt = b_type; cl = c_lat;
      end
      e = pack(4'b0111, 12'h0, 1'b0);
      tag = "R2 wait NOP";
      if (k == int'(K_PRE)) begin
        e = pack(4'b0010, 12'h400, 1'b0); tag = "R3 precharge all";
      end else if (k > int'(K_PRE) && k < int'(K_REF0)) begin
        tag = "R4 tRP gap";
      end else if (k >= int'(K_REF0) && k < int'(K_LMR)) begin
        tag = "R5 refresh schedule";
        if ((k - int'(K_REF0)) % int'(T_RC) == 0) e = pack(4'b0001, 12'h0, 1'b0);
      end else if (k == int'(K_LMR)) begin
        e = pack(4'b0000, {5'b0, c_lat, b_type, b_len}, 1'b0);
        tag = late_cfg ? "R8 load-edge config" : "R6 mode load";
      end else if (k > int'(K_LMR)) begin
        tag = "R7 ready timing";
        e = pack(4'b0111, 12'h0, k >= int'(K_RDY));
      end
      chk(bus() === e, tag, bus(), e);
      if (bus() !== e) break;
    end
  endtask

  task automatic run_reset_mid();
    bl = 3'd2; bt = 1'b0; cl = 3'd3;
    reset_check();
    rst_n = 1'b1;
    repeat (K_REF0 + 1) @(negedge clk);
    rst_n = 1'b0;
    #1;
    // R9: immediate return to inhibit, ready low
    chk(bus() === pack(4'b1111, 12'h0, 1'b0), "R9 mid-sequence reset", bus(), pack(4'b1111, 12'h0, 1'b0));
  endtask

  initial begin
    // R1 R2 R3 R4 R5 R6 R7
    run_sequence(3'd3, 1'b0, 3'd2, 1'b0);
    // R6 second pattern
    run_sequence(3'd7, 1'b1, 3'd3, 1'b0);
    // R9: reset after first refresh, then R2..R7 again on restart
    run_reset_mid();
    run_sequence(3'd1, 1'b1, 3'd2, 1'b0);
    // R8
    run_sequence(3'd2, 1'b0, 3'd3, 1'b1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule